// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block gathers single-cycle hardware event pulses into a small set of pending words. Each pending word is paired with one mask word in each of three mask banks. Each bank drives one level-sensitive interrupt request. A request stays high while at least one pending bit that its bank enables is still set. Software acknowledges events by writing ones to the pending bits it has handled. Any request left with no enabled pending bit drops on the next clock edge.

All registers share one write port and one combinational read port. An address is split into a 2-bit region field in the upper bits and a word index in the lower bits. Region 0 selects the pending words. Regions 1, 2 and 3 select mask banks A, B and C. The three requests have fixed priority levels: A is 13, B is 11 and C is 9. The block also reports the level of the highest active request as a single code.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset, every pending and mask word is zero, `irq_req` is 3'b000 and `irq_level` is 0.
- R2: A one on bit `i*WORD_W+k` of `evt_i` sets bit k of pending word i on the next clock edge, whatever the masks hold.
- R3: A write to region 0 (address bits [3:2] = 2'b00) with word index i clears, on the next clock edge, exactly those bits of pending word i that are one in `wr_data`. All other bits of that word are unchanged.
- R4: When an event pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: A write to region b+1 (A=1, B=2, C=3) with word index i stores `wr_data` into mask word i of bank b. Reading the same address on `rd_addr` returns the stored value.
- R6: `irq_req[b]` (bit 0 = A, bit 1 = B, bit 2 = C) is high exactly when, for some word i, pending word i ANDed with mask word i of bank b is nonzero. This holds for every word, not only word 0.
- R7: A request is level-held: it does not fall in a cycle with no write. It falls right after the clock edge of a clearing write that leaves no pending bit enabled in its bank.
- R8: A mask write changes the request right after its clock edge. Setting a mask bit over a bit that was already pending raises the request. Clearing the mask bit drops the request. No masked event is remembered.
- R9: `irq_level` is 13 when request A is high. Otherwise it is 11 when B is high, 9 when C is high, and 0 when no request is high.
- R10: An address whose word index is NUM_WORDS or more (for example index 3 with three words) is ignored on write and reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_WORDS*WORD_W | Event pulses, one per pending bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | IDX_W+2 | Write address: region in upper 2 bits, word index below |
| wr_data | input | WORD_W | Write data (ones clear pending bits; mask value for mask regions) |
| rd_addr | input | IDX_W+2 | Read address, same layout as wr_addr |
| rd_data | output | WORD_W | Contents of the addressed register, zero if out of range |
| pending_o | output | NUM_WORDS*WORD_W | All pending words, word i at bits [i*WORD_W +: WORD_W] |
| mask_o | output | 3*NUM_WORDS*WORD_W | All mask words, bank b word i at [(b*NUM_WORDS+i)*WORD_W +: WORD_W] |
| irq_req | output | 3 | Level requests, bit 0 = bank A, 1 = B, 2 = C |
| irq_level | output | 4 | Level of highest active request, 0 if none |

## Verification
The aggregation is exercised with a pending bit that arrives before its mask. This separates a purely combinational request from one that latches masked events. It is also exercised with bits in the first and last pending words under different banks, which shows that every word feeds the OR and that each bank uses only its own masks. Clearing writes that miss and then hit the enabled bit separate true write-one-to-clear from plain overwrite. A write and an event on the same bit in one cycle shows which of the two wins. Writes to an index past the last word confirm that the decoder drops them and does not alias them onto a real word.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int NUM_BANKS = 3;
   localparam int RGN_W     = 2;

   typedef enum logic [RGN_W-1:0] {
      RGN_PEND   = 2'd0,
      RGN_BANK_A = 2'd1,
      RGN_BANK_B = 2'd2,
      RGN_BANK_C = 2'd3
   } region_e;

   // Fixed priority level carried by each bank's request line.
   function automatic logic [3:0] bank_level(input int b);
      case (b)
         0:       return 4'd13;
         1:       return 4'd11;
         default: return 4'd9;
      endcase
   endfunction
endpackage

// File: rtl/evt_pend_word.sv
module evt_pend_word #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] set_i,
   input  logic [WORD_W-1:0] clr_i,
   output logic [WORD_W-1:0] q_o
);
   // Set has priority over clear on the same bit.
   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
   parameter int NUM_WORDS = 3,
   parameter int WORD_W    = 32,
   parameter int IDX_W     = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  logic [IDX_W-1:0]              widx_i,
   input  logic [WORD_W-1:0]             wdata_i,
   input  logic [NUM_WORDS*WORD_W-1:0]   pend_i,
   output logic [NUM_WORDS*WORD_W-1:0]   mask_o,
   output logic                          hit_o
);
   localparam int FLAT_W = NUM_WORDS * WORD_W;

   logic [WORD_W-1:0] mask_q [NUM_WORDS];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            mask_q[w] <= '0;
         else if (we_i && widx_i == IDX_W'(w))
            mask_q[w] <= wdata_i;
      end
      assign mask_o[w*WORD_W +: WORD_W] = mask_q[w];
   end

   logic [FLAT_W-1:0] enabled;
   assign enabled = pend_i & mask_o;
   assign hit_o   = |enabled;
endmodule

// File: rtl/evt_irq_prio.sv
module evt_irq_prio
   import evt_irq_pkg::*;
(
   input  logic [NUM_BANKS-1:0] req_i,
   output logic [3:0]           level_o
);
   // Walk from lowest to highest priority; the last active bank wins.
   always_comb begin
      level_o = 4'd0;
      for (int b = NUM_BANKS - 1; b >= 0; b--) begin
         if (req_i[b]) level_o = bank_level(b);
      end
   end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
   import evt_irq_pkg::*;
#(
   parameter int NUM_WORDS = 3,
   parameter int WORD_W    = 32,
   localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
   localparam int ADDR_W   = IDX_W + RGN_W
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_WORDS*WORD_W-1:0]         evt_i,
   input  logic                                wr_en,
   input  logic [ADDR_W-1:0]                   wr_addr,
   input  logic [WORD_W-1:0]                   wr_data,
   input  logic [ADDR_W-1:0]                   rd_addr,
   output logic [WORD_W-1:0]                   rd_data,
   output logic [NUM_WORDS*WORD_W-1:0]         pending_o,
   output logic [NUM_BANKS*NUM_WORDS*WORD_W-1:0] mask_o,
   output logic [NUM_BANKS-1:0]                irq_req,
   output logic [3:0]                          irq_level
);
   localparam int                BANK_FLAT = NUM_WORDS * WORD_W;
   localparam logic [IDX_W:0]    NW_C      = (IDX_W+1)'(NUM_WORDS);

   // Address decode
   logic [RGN_W-1:0] wr_rgn, rd_rgn;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic             wr_ok, rd_ok;

   assign wr_rgn = wr_addr[ADDR_W-1 -: RGN_W];
   assign wr_idx = wr_addr[IDX_W-1:0];
   assign rd_rgn = rd_addr[ADDR_W-1 -: RGN_W];
   assign rd_idx = rd_addr[IDX_W-1:0];
   assign wr_ok  = ({1'b0, wr_idx} < NW_C);
   assign rd_ok  = ({1'b0, rd_idx} < NW_C);

   // Register view: index 0 is pending, index b+1 is mask bank b.
   logic [WORD_W-1:0] reg_w [NUM_BANKS+1][NUM_WORDS];

   // Pending words
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_pend
      logic [WORD_W-1:0] clr;
      assign clr = (wr_en && wr_ok && wr_rgn == RGN_PEND && wr_idx == IDX_W'(w))
                   ? wr_data : '0;
      evt_pend_word #(.WORD_W(WORD_W)) u_word (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (evt_i[w*WORD_W +: WORD_W]),
         .clr_i (clr),
         .q_o   (pending_o[w*WORD_W +: WORD_W])
      );
      assign reg_w[0][w] = pending_o[w*WORD_W +: WORD_W];
   end

   // Mask banks, one request line each
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_we;
      assign bank_we = wr_en && wr_ok && (wr_rgn == RGN_W'(b + 1));
      evt_mask_bank #(
         .NUM_WORDS (NUM_WORDS),
         .WORD_W    (WORD_W),
         .IDX_W     (IDX_W)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_i    (bank_we),
         .widx_i  (wr_idx),
         .wdata_i (wr_data),
         .pend_i  (pending_o),
         .mask_o  (mask_o[b*BANK_FLAT +: BANK_FLAT]),
         .hit_o   (irq_req[b])
      );
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_view
         assign reg_w[b+1][w] = mask_o[(b*NUM_WORDS + w)*WORD_W +: WORD_W];
      end
   end

   evt_irq_prio u_prio (
      .req_i   (irq_req),
      .level_o (irq_level)
   );

   // Read mux
   always_comb begin
      rd_data = '0;
      for (int k = 0; k <= NUM_BANKS; k++) begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_ok && rd_rgn == RGN_W'(k) && rd_idx == IDX_W'(w))
               rd_data = reg_w[k][w];
         end
      end
   end
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk
   import evt_irq_pkg::*;
#(
   parameter int NUM_WORDS = 3,
   parameter int WORD_W    = 32,
   parameter int IDX_W     = 2
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic [NUM_WORDS*WORD_W-1:0]           evt_i,
   input logic                                  wr_en,
   input logic [IDX_W+RGN_W-1:0]                wr_addr,
   input logic [WORD_W-1:0]                     wr_data,
   input logic [NUM_WORDS*WORD_W-1:0]           pending_o,
   input logic [NUM_BANKS*NUM_WORDS*WORD_W-1:0] mask_o,
   input logic [NUM_BANKS-1:0]                  irq_req,
   input logic [3:0]                            irq_level
);
   localparam logic [IDX_W:0] NW_C = (IDX_W+1)'(NUM_WORDS);

   logic bad_idx;
   assign bad_idx = ({1'b0, wr_addr[IDX_W-1:0]} >= NW_C);

   // R2: every pulsed bit is pending after the edge
   a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((pending_o & $past(evt_i)) == $past(evt_i)));

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
      // R3 and R4: clear by ones, set wins
      a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == {RGN_PEND, IDX_W'(w)})
         |=> (pending_o[w*WORD_W +: WORD_W] ==
              (($past(pending_o[w*WORD_W +: WORD_W]) & ~$past(wr_data))
               | $past(evt_i[w*WORD_W +: WORD_W]))));
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
      // R7: request is held while nothing is written
      a_r7_held: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_en && irq_req[b]) |=> irq_req[b]);
   end

   // R9: level encoding follows the fixed priority
   a_r9_lvl_a: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[0] |-> (irq_level == 4'd13));
   a_r9_lvl_b: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[1:0] == 2'b10) |-> (irq_level == 4'd11));
   a_r9_lvl_none: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req == '0) |-> (irq_level == 4'd0));

   // R10: out-of-range index leaves the masks alone
   a_r10_bad_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bad_idx) |=> $stable(mask_o));
endmodule

bind evt_irq_agg evt_irq_agg_chk #(
   .NUM_WORDS (NUM_WORDS),
   .WORD_W    (WORD_W),
   .IDX_W     (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_i     (evt_i),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .pending_o (pending_o),
   .mask_o    (mask_o),
   .irq_req   (irq_req),
   .irq_level (irq_level)
);

// File: tb/evt_irq_agg_test.sv
module evt_irq_agg_test;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 3;
   localparam int W  = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NW*W-1:0] evt_i = '0;
   logic            wr_en = 1'b0;
   logic [3:0]      wr_addr = '0;
   logic [W-1:0]    wr_data = '0;
   logic [3:0]      rd_addr = '0;
   logic [W-1:0]    rd_data;
   logic [NW*W-1:0] pending_o;
   logic [3*NW*W-1:0] mask_o;
   logic [2:0]      irq_req;
   logic [3:0]      irq_level;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_irq_agg uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .pending_o(pending_o), .mask_o(mask_o),
      .irq_req(irq_req), .irq_level(irq_level)
   );

   task automatic check(input string req, input logic [287:0] act, input logic [287:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [3:0] a,
                       input logic [W-1:0] d, input logic [NW*W-1:0] e);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; evt_i = e;
      @(negedge clk);
      wr_en = 1'b0; evt_i = '0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
      step(1'b1, a, d, '0);
   endtask

   task automatic ev(input logic [NW*W-1:0] e);
      step(1'b0, 4'h0, '0, e);
   endtask

   task automatic rd_check(input string req, input logic [3:0] a, input logic [W-1:0] exp);
      rd_addr = a;
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic t_reset();
      check("R1 pending", pending_o, '0);
      check("R1 mask", mask_o, '0);
      check("R1 irq", irq_req, 3'b000);
      check("R1 level", irq_level, 4'd0);
   endtask

   task automatic t_event_unmasked();
      ev(96'h20);
      check("R2 pending set", pending_o, 96'h20);
      check("R2 no irq while masked", irq_req, 3'b000);
   endtask

   task automatic t_mask_after_event();
      wr(4'h4, 32'h20);
      check("R8 late unmask raises A", irq_req, 3'b001);
      check("R9 level A", irq_level, 4'd13);
      rd_check("R5 mask A readback", 4'h4, 32'h20);
      rd_check("R5 pending readback", 4'h0, 32'h20);
   endtask

   task automatic t_clear();
      wr(4'h0, 32'hFFFF_FFDF);
      check("R3 other bits untouched", pending_o, 96'h20);
      check("R7 held after miss", irq_req, 3'b001);
      wr(4'h0, 32'h20);
      check("R3 bit cleared", pending_o, '0);
      check("R7 drops after clear", irq_req, 3'b000);
   endtask

   task automatic t_multiword();
      wr(4'hE, 32'h8000_0000);
      ev({32'h8000_0000, 64'h0});
      check("R6 word2 feeds C", irq_req, 3'b100);
      check("R9 level C", irq_level, 4'd9);
      wr(4'h9, 32'h1);
      ev({32'h0, 32'h1, 32'h0});
      check("R6 word1 feeds B", irq_req, 3'b110);
      check("R9 level B over C", irq_level, 4'd11);
      wr(4'h2, 32'h8000_0000);
      check("R7 C drops, B held", irq_req, 3'b010);
   endtask

   task automatic t_set_wins();
      step(1'b1, 4'h1, 32'h1, {32'h0, 32'h1, 32'h0});
      check("R4 set beats clear", pending_o, {32'h0, 32'h1, 32'h0});
   endtask

   task automatic t_bad_index();
      logic [287:0] exp_mask;
      exp_mask = '0;
      exp_mask[31:0]    = 32'h20;
      exp_mask[159:128] = 32'h1;
      exp_mask[287:256] = 32'h8000_0000;
      wr(4'h7, 32'hFFFF_FFFF);
      check("R10 mask write ignored", mask_o, exp_mask);
      wr(4'h3, 32'hFFFF_FFFF);
      check("R10 pending write ignored", pending_o, {32'h0, 32'h1, 32'h0});
      rd_check("R10 read returns zero", 4'h7, 32'h0);
      wr(4'h9, 32'h0);
      check("R8 mask clear drops B", irq_req, 3'b000);
      check("R9 level none", irq_level, 4'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_event_unmasked();
      t_mask_after_event();
      t_clear();
      t_multiword();
      t_set_wins();
      t_bad_index();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL timeout: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule